// File: doc/BRIEF.md
# PWM Channel Status and Control Register

This block is the status and control word of a single PWM generator channel. Software reaches it through a plain single-register write port and a read-data bus. The block holds four sticky event flags fed from four external event levels: synchronisation, fault, current limit and feed-forward. Next to each flag it shows the live level of the same input. A flag latches when its input rises while the channel is enabled. It also latches when the channel becomes enabled while the input is already high.

Writing ones to strobe positions in the word starts or stops a PWM cycle, or asks the PWM core to take over new data values. The word then reports the resulting run state and update-pending state. While an update is pending, the block refuses writes to the channel's data registers. It also keeps a capture flag raised by the core, and it mirrors two phase indications from the core: the push-pull cycle and the center-aligned half. The time base, the comparators and the capture counter live in the core and connect through the pulse and level ports below.

Top module: `pwm_stat_reg`

## Requirements
- R1: Event flag k (read bit 12+k; k=3 sync, 2 fault, 1 current limit, 0 feed-forward, with input `evt_lvl[k]` feeding it) becomes 1 one clock after a clock edge where `mod_en` is 1, `evt_lvl[k]` is 1 and `evt_lvl[k]` was 0 at the previous edge.
- R2: An event flag also becomes 1 one clock after the first edge at which `mod_en` is 1 following an edge where it was 0, when its input is high at that edge. While `mod_en` is 0 no event flag is set.
- R3: Writing 1 to read bit 12+k clears event flag k, and writing 0 there leaves it unchanged. If a set and a clear meet at the same edge, the flag ends up 1.
- R4: Read bits 11..8 show the current levels of `evt_lvl[3:0]` in that order, with no clock delay.
- R5: A write with bit 7 set makes the run status (read bit 0, output `gen_run`) 1 from the next clock. A write with bit 6 set makes it 0. When both bits are set in the same write, the status ends up 0.
- R6: An edge with `cyc_end` = 1 and `one_shot` = 1 clears the run status. With `one_shot` = 0, `cyc_end` has no effect on it.
- R7: A write with bit 3 set raises `upd_req` in the same cycle and sets the update-pending flag (read bit 4) from the next clock. A pulse on `upd_done` clears the pending flag, unless a new request arrives at the same edge, in which case the flag stays 1.
- R8: `data_wr_grant` equals `data_wr_req` while the pending flag is 0, and is 0 while the flag is 1.
- R9: A pulse on `cap_pulse` sets the capture flag (read bit 5). Writing 1 to bit 5 clears it. If a set and a clear meet at the same edge, the flag ends up 1.
- R10: Read bit 2 shows `steer_ph` (0 = first push-pull cycle, 1 = second), and read bit 1 shows `half_ph` (0 = first half, 1 = second half), both without delay.
- R11: Read bits 31..16, 7, 6 and 3 always read 0.
- R12: A clock edge with `rst_n` = 0 clears every stored bit, including the remembered previous input and enable levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data |
| mod_en | input | 1 | Channel enable |
| evt_lvl | input | 4 | Event levels: [3] sync, [2] fault, [1] current limit, [0] feed-forward |
| cap_pulse | input | 1 | One-cycle pulse from the core when the time base has been captured |
| upd_done | input | 1 | One-cycle pulse from the core when the data update has been taken |
| cyc_end | input | 1 | One-cycle pulse from the core at the end of a PWM cycle |
| one_shot | input | 1 | 1 when the generator runs in single-shot mode |
| steer_ph | input | 1 | Push-pull cycle indicator from the core |
| half_ph | input | 1 | Center-aligned half indicator from the core |
| data_wr_req | input | 1 | Write request toward the channel's data registers |
| data_wr_grant | output | 1 | That write is allowed through |
| gen_run | output | 1 | Run status to the core |
| upd_req | output | 1 | One-cycle update request to the core |

## Verification
Several hardware sets can land on the same edge as a software action. An event or capture set can meet a write-one clear, an update-done pulse can meet a new request, and a stop write, an end-of-cycle pulse or a start write can all hit the run status at once. The bench forces each of these pairs in directed steps, then runs long weighted-random stretches in which writes, pulses and level changes collide often. A behavioural model steps one clock at a time and applies the stated priorities: set over clear, request over done, any clear of the run status over start. Every readback field and output is compared with that model in every cycle.

// File: rtl/pwm_stat_pkg.sv
// Package: field positions and widths of the channel status word.
// Assumes a 16-bit implemented word inside a wider read bus.
package pwm_stat_pkg;
    localparam int N_EVT      = 4;
    localparam int REG_W      = 16;
    localparam int POS_STICKY = 12;
    localparam int POS_LIVE   = 8;
    localparam int POS_START  = 7;
    localparam int POS_STOP   = 6;
    localparam int POS_CAP    = 5;
    localparam int POS_PEND   = 4;
    localparam int POS_UREQ   = 3;
    localparam int POS_STEER  = 2;
    localparam int POS_HALF   = 1;
    localparam int POS_RUN    = 0;
endpackage

// File: rtl/pwm_evt_flag.sv
// Module: one sticky event flag.
// Sets on a rising input while enabled, or when enable rises with the input
// already high. Clears on a software clear strobe; a set beats the clear.
module pwm_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lvl_i,
    input  logic clr_i,
    output logic flag_o
);
    logic lvl_q;
    logic en_q;
    logic set_w;

    // Set condition: new edge on the input, or fresh enable with input high.
    always_comb set_w = en_i && lvl_i && (!lvl_q || !en_q);

    // Remember previous input and enable levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            lvl_q <= lvl_i;
            en_q  <= en_i;
        end
    end

    // Sticky flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_w)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    AST_EVT_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && lvl_i && !lvl_q) |=> flag_o);                 // R1
    AST_EVT_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !flag_o) |=> !flag_o);                        // R2
    AST_EVT_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !en_i) |=> !flag_o);                          // R3
endmodule

// File: rtl/pwm_run_ctl.sv
// Module: run status and data-update handshake.
// Assumes start/stop/request strobes and core pulses last one cycle.
// Any clearing source of the run status beats start; a request beats done.
module pwm_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic cyc_end_i,
    input  logic one_shot_i,
    input  logic req_i,
    input  logic done_i,
    output logic run_o,
    output logic pend_o
);
    logic run_clr_w;

    // Sources that end the running cycle.
    always_comb run_clr_w = stop_i || (cyc_end_i && one_shot_i);

    // Run status register.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_o <= 1'b0;
        else if (run_clr_w) run_o <= 1'b0;
        else if (start_i)   run_o <= 1'b1;
    end

    // Update-pending register.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (req_i)   pend_o <= 1'b1;
        else if (done_i)  pend_o <= 1'b0;
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !run_o);                                     // R5
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i && !cyc_end_i) |=> run_o);          // R5
    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end_i && one_shot_i) |=> !run_o);                  // R6
    AST_UPD_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pend_o);                                      // R7
    AST_UPD_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !req_i) |=> !pend_o);                        // R7
endmodule

// File: rtl/pwm_stat_reg.sv
// Module: top of the PWM channel status/control register.
// Decodes write strobes, holds the capture flag, instantiates one sticky
// flag per event input and assembles the read word. Assumes the register
// is selected whenever bus_wr is high.
module pwm_stat_reg #(
    parameter int RD_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_wr,
    input  logic [pwm_stat_pkg::REG_W-1:0]     bus_wdata,
    output logic [RD_W-1:0]                    bus_rdata,
    input  logic                               mod_en,
    input  logic [pwm_stat_pkg::N_EVT-1:0]     evt_lvl,
    input  logic                               cap_pulse,
    input  logic                               upd_done,
    input  logic                               cyc_end,
    input  logic                               one_shot,
    input  logic                               steer_ph,
    input  logic                               half_ph,
    input  logic                               data_wr_req,
    output logic                               data_wr_grant,
    output logic                               gen_run,
    output logic                               upd_req
);
    import pwm_stat_pkg::*;

    localparam int EVT_TOP = POS_STICKY + N_EVT - 1;
    localparam int LIV_TOP = POS_LIVE + N_EVT - 1;

    logic [N_EVT-1:0] sticky_w;
    logic [N_EVT-1:0] clr_w;
    logic             start_w;
    logic             stop_w;
    logic             pend_w;
    logic             cap_q;

    // Write-one strobes decoded from the bus.
    always_comb begin
        clr_w   = bus_wr ? bus_wdata[EVT_TOP:POS_STICKY] : '0;
        start_w = bus_wr && bus_wdata[POS_START];
        stop_w  = bus_wr && bus_wdata[POS_STOP];
        upd_req = bus_wr && bus_wdata[POS_UREQ];
    end

    // One sticky flag per event input.
    for (genvar k = 0; k < N_EVT; k++) begin : g_evt
        pwm_evt_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (mod_en),
            .lvl_i  (evt_lvl[k]),
            .clr_i  (clr_w[k]),
            .flag_o (sticky_w[k])
        );
    end

    pwm_run_ctl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .cyc_end_i  (cyc_end),
        .one_shot_i (one_shot),
        .req_i      (upd_req),
        .done_i     (upd_done),
        .run_o      (gen_run),
        .pend_o     (pend_w)
    );

    // Capture flag: hardware set beats software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cap_q <= 1'b0;
        else if (cap_pulse)                       cap_q <= 1'b1;
        else if (bus_wr && bus_wdata[POS_CAP])    cap_q <= 1'b0;
    end

    // Data-register writes are refused while an update is pending.
    always_comb data_wr_grant = data_wr_req && !pend_w;

    // Read word assembly; unlisted bits stay 0.
    always_comb begin
        bus_rdata                      = '0;
        bus_rdata[EVT_TOP:POS_STICKY]  = sticky_w;
        bus_rdata[LIV_TOP:POS_LIVE]    = evt_lvl;
        bus_rdata[POS_CAP]             = cap_q;
        bus_rdata[POS_PEND]            = pend_w;
        bus_rdata[POS_STEER]           = steer_ph;
        bus_rdata[POS_HALF]            = half_ph;
        bus_rdata[POS_RUN]             = gen_run;
    end

    AST_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> bus_rdata[POS_CAP]);                      // R9
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> !data_wr_grant);                            // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata[EVT_TOP:POS_STICKY] == '0) && !gen_run && !pend_w && !cap_q); // R12
endmodule

// File: tb/pwm_stat_reg_test.sv
module pwm_stat_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mod_en = 1'b0;
    logic [3:0]  evt_lvl = '0;
    logic        cap_pulse = 1'b0, upd_done = 1'b0, cyc_end = 1'b0, one_shot = 1'b0;
    logic        steer_ph = 1'b0, half_ph = 1'b0, data_wr_req = 1'b0;
    logic        data_wr_grant, gen_run, upd_req;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state
    bit [3:0] m_stk = '0, m_prev = '0;
    bit       m_pen = 0, m_run = 0, m_pend = 0, m_cap = 0;

    always #10 clk = ~clk;

    pwm_stat_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mod_en(mod_en), .evt_lvl(evt_lvl),
        .cap_pulse(cap_pulse), .upd_done(upd_done), .cyc_end(cyc_end),
        .one_shot(one_shot), .steer_ph(steer_ph), .half_ph(half_ph),
        .data_wr_req(data_wr_req), .data_wr_grant(data_wr_grant),
        .gen_run(gen_run), .upd_req(upd_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Model step at a clock edge using the inputs driven for that cycle.
    task automatic model_edge();
        bit wr3, st, sp;
        if (!rst_n) begin
            m_stk = '0; m_prev = '0; m_pen = 0; m_run = 0; m_pend = 0; m_cap = 0;
            return;
        end
        for (int k = 0; k < 4; k++) begin
            bit s, c;
            s = mod_en && evt_lvl[k] && (!m_prev[k] || !m_pen);
            c = bus_wr && bus_wdata[12+k];
            if (s) m_stk[k] = 1; else if (c) m_stk[k] = 0;
        end
        m_prev = evt_lvl; m_pen = mod_en;
        st = bus_wr && bus_wdata[7]; sp = bus_wr && bus_wdata[6];
        if (sp || (cyc_end && one_shot)) m_run = 0; else if (st) m_run = 1;
        wr3 = bus_wr && bus_wdata[3];
        if (wr3) m_pend = 1; else if (upd_done) m_pend = 0;
        if (cap_pulse) m_cap = 1; else if (bus_wr && bus_wdata[5]) m_cap = 0;
    endtask

    // Compare all outputs with the model (called away from the edge).
    task automatic compare();
        chk("R1/R2/R3 sticky", {28'h0, bus_rdata[15:12]}, {28'h0, m_stk});
        chk("R4 live", {28'h0, bus_rdata[11:8]}, {28'h0, evt_lvl});
        chk("R5/R6 run bit", {31'h0, bus_rdata[0]}, {31'h0, m_run});
        chk("R5/R6 gen_run", {31'h0, gen_run}, {31'h0, m_run});
        chk("R7 pending", {31'h0, bus_rdata[4]}, {31'h0, m_pend});
        chk("R7 upd_req", {31'h0, upd_req}, {31'h0, bus_wr && bus_wdata[3]});
        chk("R8 grant", {31'h0, data_wr_grant}, {31'h0, data_wr_req && !m_pend});
        chk("R9 capture", {31'h0, bus_rdata[5]}, {31'h0, m_cap});
        chk("R10 phases", {30'h0, bus_rdata[2:1]}, {30'h0, steer_ph, half_ph});
        chk("R11 zero bits", {bus_rdata[31:16], 12'h0, bus_rdata[7:6], 1'b0, bus_rdata[3]}, 32'h0);
    endtask

    // One cycle: inputs already set; edge; model; compare at negedge.
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_inputs();
        bus_wr = 0; bus_wdata = '0; cap_pulse = 0; upd_done = 0; cyc_end = 0;
    endtask

    task automatic wr(input logic [15:0] d);
        bus_wr = 1; bus_wdata = d;
    endtask

    initial begin
        @(negedge clk);
        rst_n = 0; mod_en = 1; evt_lvl = 4'hF;
        cycle(); cycle();
        // R12: after reset, stored bits are 0 (live bits show levels)
        chk("R12 reset word", bus_rdata & 32'hF0FF, 32'h0);
        rst_n = 1;
        cycle();  // R2: enable already high, prev cleared by reset -> all flags set
        chk("R2 flags after reset with high inputs", {28'h0, bus_rdata[15:12]}, 32'hF);
        // R3: write 0 no effect, write 1 clears
        evt_lvl = 4'h0; wr(16'h0000); cycle();
        chk("R3 write zero keeps", {28'h0, bus_rdata[15:12]}, 32'hF);
        wr(16'h5000); cycle();
        chk("R3 clear selected", {28'h0, bus_rdata[15:12]}, 32'hA);
        // R3: set and clear same edge -> set
        wr(16'hF000); evt_lvl = 4'h1; cycle();
        chk("R3 set beats clear", {28'h0, bus_rdata[15:12]}, 32'h1);
        // R2: disabled no set, re-enable with high input sets
        idle_inputs(); wr(16'hF000); evt_lvl = 4'h0; cycle();
        idle_inputs(); mod_en = 0; evt_lvl = 4'h4; cycle(); cycle();
        chk("R2 no set while off", {28'h0, bus_rdata[15:12]}, 32'h0);
        mod_en = 1; cycle();
        chk("R2 set on enable", {28'h0, bus_rdata[15:12]}, 32'h4);
        // R5: start then start+stop
        wr(16'h0080); cycle();
        chk("R5 start", {31'h0, gen_run}, 32'h1);
        wr(16'h00C0); cycle();
        chk("R5 stop wins", {31'h0, gen_run}, 32'h0);
        // R6: continuous mode ignores end, one-shot clears
        wr(16'h0080); cycle(); idle_inputs();
        cyc_end = 1; one_shot = 0; cycle();
        chk("R6 continuous keeps run", {31'h0, gen_run}, 32'h1);
        one_shot = 1; cycle();
        chk("R6 one-shot end clears", {31'h0, gen_run}, 32'h0);
        idle_inputs(); one_shot = 0;
        // R7: request + done same edge keeps pending
        wr(16'h0008); data_wr_req = 1; cycle();
        idle_inputs(); cycle();
        chk("R8 grant blocked", {31'h0, data_wr_grant}, 32'h0);
        wr(16'h0008); upd_done = 1; cycle();
        chk("R7 request beats done", {31'h0, bus_rdata[4]}, 32'h1);
        idle_inputs(); upd_done = 1; cycle();
        chk("R7 done clears", {31'h0, bus_rdata[4]}, 32'h0);
        // R9: capture set beats clear
        idle_inputs(); cap_pulse = 1; wr(16'h0020); cycle();
        chk("R9 set beats clear", {31'h0, bus_rdata[5]}, 32'h1);
        idle_inputs(); wr(16'h0020); cycle();
        chk("R9 clear", {31'h0, bus_rdata[5]}, 32'h0);
        idle_inputs();
        // random stretch
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] r;
            r = $urandom;
            bus_wr = (r[3:0] < 5);
            bus_wdata = 16'($urandom);
            cap_pulse = (r[6:4] == 0);
            upd_done = (r[9:7] < 2);
            cyc_end = (r[12:10] < 2);
            one_shot = r[13];
            steer_ph = r[14]; half_ph = r[15];
            data_wr_req = r[16];
            if (r[20:17] < 4) evt_lvl = 4'($urandom);
            if (r[24:21] == 0) mod_en = ~mod_en;
            rst_n = !(r[31:25] == 0);
            cycle();
        end
        rst_n = 1; idle_inputs(); cycle();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule